// File: doc/BRIEF.md
# Head Cache with Lookahead Replenishment

This block is the read side of a packet buffer that keeps the bulk of every queue in slow wide memory. Only a small head cache of cells for each queue lives in fast on-chip storage. A scheduler presents at most one read request per time slot. Each request names one of `Q` queues. The request enters a delay line of fixed length. While the request moves through that line, the block looks at every request still waiting. Once every `b` slots it may order one block read of `b` cells for a single queue from the bulk memory.

The choice of queue looks ahead rather than reacting to misses. For each queue the block adds the cells already cached to the cells in flight. It then walks the waiting requests from oldest to newest and subtracts one for each request to that queue. The first queue whose running balance goes below zero is the most urgent, and it gets the refill. If no balance goes below zero, no refill is ordered. Because the delay line is longer than the worst-case time a queue can wait to be served, the head cell is always present when a request reaches the end of the line. Each request is therefore answered after the same number of cycles.

The bulk memory is outside the block. It receives a read command (`bulk_rd_valid`, `bulk_rd_qid`) and must return the `b` cells for that queue on `bulk_rd_data` exactly `RD_LAT` cycles later. Cell `k` of the block sits in bits `[k*DW +: DW]`, and the cells are in queue order.

Top module: `hc_head_cache`

## Requirements
- R1: A request accepted at a clock edge (`req_valid` high) appears at `cell_valid`/`cell_qid` exactly `PIPE` cycles later, where `PIPE = Q*(B-1)+1+RD_LAT+1`. With the defaults Q=4, B=4, RD_LAT=1 this gives 15 cycles. `cell_qid` repeats the requested queue index.
- R2: Every accepted request produces exactly one output cell, and `cell_valid` is never high without a matching request. No request ever finds its queue's head cache empty.
- R3: For each queue, cells leave in the order in which the bulk memory delivered them for that queue. Cell `k` of a bulk block is taken from bits `[k*DW +: DW]` of `bulk_rd_data`, and the cell is carried unchanged to `cell_data`.
- R4: A bulk read command for `B` cells is issued at most once every `B` cycles. Commands only appear on cycles whose distance from one another is a multiple of `B`.
- R5: A bulk read command for queue `q` is issued only when the cells already fetched for `q` are fewer than the requests accepted for `q`. When no requests are waiting, no command is issued.
- R6: When several queues run short, the command goes to the queue whose first uncovered request is oldest in the delay line, not to the lowest queue index.
- R7: The bulk memory block for a command is sampled from `bulk_rd_data` exactly `RD_LAT` cycles after the command is shown on `bulk_rd_valid`.
- R8: While `rst_n` is low, `cell_valid` and `bulk_rd_valid` are low. After reset, all cached and waiting state is empty, and the delay line restarts from an empty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A read request is present this slot |
| req_qid | input | $clog2(Q) | Queue named by the request |
| bulk_rd_valid | output | 1 | Bulk block read command |
| bulk_rd_qid | output | $clog2(Q) | Queue to be refilled |
| bulk_rd_data | input | B*DW | B cells returned RD_LAT cycles after the command |
| cell_valid | output | 1 | A cell leaves this cycle |
| cell_qid | output | $clog2(Q) | Queue of the leaving cell |
| cell_data | output | DW | Leaving cell |

## Verification
The bench sends two short requests to queues 3 and 1, and later to queues 2 and 0. The urgent pick must follow the age of the requests. A design that fell back to the lowest index would refill queue 1 or queue 0 first, and a later request would find its head cache short. Long runs to one queue, round-robin sweeps and random mixes check that every cell leaves after the fixed delay, in per-queue order. A design with a short lookahead or an off-by-one balance would drop or delay cells there. Every bulk command is also checked for spacing and for real need. This catches a design that refills on a wrong phase or fetches for queues with no waiting demand. A reset in the middle of traffic must clear every waiting request and restart the per-queue order.

// File: rtl/hc_pkg.sv
package hc_pkg;

    localparam int HC_QUEUES_DEF = 4;
    localparam int HC_BLOCK_DEF  = 4;
    localparam int HC_RDLAT_DEF  = 1;
    localparam int HC_DW_DEF     = 16;

    // Delay line length: lookahead span plus the bulk read latency plus
    // one slot for the issue register.
    function automatic int hc_pipe_depth(int nq, int blk, int rdlat);
        return nq * (blk - 1) + 1 + rdlat + 1;
    endfunction

    // Per-queue head storage, a power of two that covers the deepest
    // balance a queue can reach.
    function automatic int hc_queue_depth(int pipe, int blk);
        return 1 << $clog2(pipe + blk);
    endfunction

endpackage

// File: rtl/hc_lookahead.sv
module hc_lookahead #(
    parameter int PIPE = 15,
    parameter int QW   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [QW-1:0]            req_qid,
    output logic [PIPE-1:0]          stg_vld,
    output logic [PIPE-1:0][QW-1:0]  stg_qid
);

    typedef struct packed {
        logic [PIPE-1:0]         vld;
        logic [PIPE-1:0][QW-1:0] qid;
    } la_t;

    la_t la_d, la_q;

    always_comb begin
        la_d = la_q;
        la_d.vld[0] = req_valid;
        la_d.qid[0] = req_qid;
        for (int i = 1; i < PIPE; i++) begin
            la_d.vld[i] = la_q.vld[i-1];
            la_d.qid[i] = la_q.qid[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) la_q <= '0;
        else        la_q <= la_d;
    end

    assign stg_vld = la_q.vld;
    assign stg_qid = la_q.qid;

endmodule

// File: rtl/hc_refill_sched.sv
module hc_refill_sched #(
    parameter int Q    = 4,
    parameter int B    = 4,
    parameter int PIPE = 15,
    parameter int LAT  = 1,
    parameter int QW   = 2,
    parameter int CW   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PIPE-1:0]          win_vld,
    input  logic [PIPE-1:0][QW-1:0]  win_qid,
    input  logic [Q-1:0][CW-1:0]     occ,
    output logic                     cmd_valid,
    output logic [QW-1:0]            cmd_qid,
    output logic                     land_valid,
    output logic [QW-1:0]            land_qid
);

    localparam int AW  = CW + $clog2(PIPE + 1) + $clog2(B * LAT + 1) + 2;
    localparam int PHW = (B < 2) ? 1 : $clog2(B);
    localparam int GW  = $clog2(B + 1);
    localparam logic signed [AW-1:0] BLK_S = AW'(B);
    localparam logic signed [AW-1:0] ONE_S = AW'(1);

    typedef struct packed {
        logic [PHW-1:0]         phase;
        logic [LAT-1:0]         fv;
        logic [LAT-1:0][QW-1:0] fq;
    } sch_t;

    sch_t s_d, s_q;

    logic signed [AW-1:0] bal [Q];
    logic                 urgent;
    logic [QW-1:0]        urgent_q;

    // Balance per queue: cached plus in flight, minus waiting demand,
    // walked from the oldest waiting request towards the newest.
    always_comb begin
        urgent   = 1'b0;
        urgent_q = '0;
        for (int q = 0; q < Q; q++) begin
            bal[q] = $signed({{(AW-CW){1'b0}}, occ[q]});
            for (int s = 0; s < LAT; s++) begin
                if (s_q.fv[s] && s_q.fq[s] == QW'(q)) bal[q] = bal[q] + BLK_S;
            end
        end
        for (int i = PIPE - 1; i >= 0; i--) begin
            if (win_vld[i]) begin
                bal[win_qid[i]] = bal[win_qid[i]] - ONE_S;
                if (!urgent && bal[win_qid[i]] < 0) begin
                    urgent   = 1'b1;
                    urgent_q = win_qid[i];
                end
            end
        end
    end

    always_comb begin
        s_d = s_q;
        s_d.phase = (s_q.phase == PHW'(B - 1)) ? '0 : s_q.phase + PHW'(1);
        s_d.fv[0] = urgent && (s_q.phase == '0);
        s_d.fq[0] = urgent_q;
        for (int s = 1; s < LAT; s++) begin
            s_d.fv[s] = s_q.fv[s-1];
            s_d.fq[s] = s_q.fq[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_valid  = s_q.fv[0];
    assign cmd_qid    = s_q.fq[0];
    assign land_valid = s_q.fv[LAT-1];
    assign land_qid   = s_q.fq[LAT-1];

    // Cycles since the last command, saturating at B.
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         gap_q <= GW'(B);
        else if (cmd_valid) gap_q <= GW'(1);
        else if (gap_q < GW'(B)) gap_q <= gap_q + GW'(1);
    end

    // R4
    refill_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> gap_q >= GW'(B));

endmodule

// File: rtl/hc_head_store.sv
module hc_head_store #(
    parameter int Q  = 4,
    parameter int B  = 4,
    parameter int QD = 32,
    parameter int DW = 16,
    parameter int QW = 2,
    parameter int CW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [QW-1:0]           wr_qid,
    input  logic [B-1:0][DW-1:0]    wr_cells,
    input  logic                    pop_valid,
    input  logic [QW-1:0]           pop_qid,
    output logic [Q-1:0][CW-1:0]    occ,
    output logic                    out_valid,
    output logic [QW-1:0]           out_qid,
    output logic [DW-1:0]           out_data
);

    localparam int PW = $clog2(QD);

    typedef struct packed {
        logic [Q*QD-1:0][DW-1:0] mem;
        logic [Q-1:0][PW-1:0]    wp;
        logic [Q-1:0][PW-1:0]    rp;
        logic [Q-1:0][CW-1:0]    cnt;
        logic                    ov;
        logic [QW-1:0]           oq;
        logic [DW-1:0]           od;
    } hs_t;

    hs_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        h_d.ov = pop_valid;
        h_d.oq = pop_qid;
        h_d.od = h_q.mem[int'(pop_qid) * QD + int'(h_q.rp[pop_qid])];
        if (pop_valid) h_d.rp[pop_qid] = h_q.rp[pop_qid] + PW'(1);
        if (wr_valid) begin
            for (int k = 0; k < B; k++) begin
                h_d.mem[int'(wr_qid) * QD + int'(PW'(h_q.wp[wr_qid] + PW'(k)))] = wr_cells[k];
            end
            h_d.wp[wr_qid] = h_q.wp[wr_qid] + PW'(B);
        end
        for (int i = 0; i < Q; i++) begin
            h_d.cnt[i] = h_q.cnt[i]
                       + ((wr_valid  && wr_qid  == QW'(i)) ? CW'(B) : CW'(0))
                       - ((pop_valid && pop_qid == QW'(i)) ? CW'(1) : CW'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign occ      = h_q.cnt;
    assign out_valid = h_q.ov;
    assign out_qid  = h_q.oq;
    assign out_data = h_q.od;

    // R2
    no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> h_q.cnt[pop_qid] != '0);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> h_q.cnt[wr_qid] <= CW'(QD - B));

endmodule

// File: rtl/hc_head_cache.sv
module hc_head_cache
    import hc_pkg::*;
#(
    parameter int Q      = HC_QUEUES_DEF,
    parameter int B      = HC_BLOCK_DEF,
    parameter int RD_LAT = HC_RDLAT_DEF,
    parameter int DW     = HC_DW_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [$clog2(Q)-1:0]   req_qid,
    output logic                   bulk_rd_valid,
    output logic [$clog2(Q)-1:0]   bulk_rd_qid,
    input  logic [B*DW-1:0]        bulk_rd_data,
    output logic                   cell_valid,
    output logic [$clog2(Q)-1:0]   cell_qid,
    output logic [DW-1:0]          cell_data
);

    localparam int QW   = $clog2(Q);
    localparam int PIPE = hc_pipe_depth(Q, B, RD_LAT);
    localparam int QD   = hc_queue_depth(PIPE, B);
    localparam int CW   = $clog2(QD + 1);

    logic [PIPE-1:0]          stg_vld;
    logic [PIPE-1:0][QW-1:0]  stg_qid;
    logic [Q-1:0][CW-1:0]     occ;
    logic                     land_valid;
    logic [QW-1:0]            land_qid;
    logic [B-1:0][DW-1:0]     rsp_cells;

    assign rsp_cells = bulk_rd_data;

    hc_lookahead #(.PIPE(PIPE), .QW(QW)) u_la (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_qid   (req_qid),
        .stg_vld   (stg_vld),
        .stg_qid   (stg_qid)
    );

    hc_refill_sched #(.Q(Q), .B(B), .PIPE(PIPE), .LAT(RD_LAT), .QW(QW), .CW(CW)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_vld    (stg_vld),
        .win_qid    (stg_qid),
        .occ        (occ),
        .cmd_valid  (bulk_rd_valid),
        .cmd_qid    (bulk_rd_qid),
        .land_valid (land_valid),
        .land_qid   (land_qid)
    );

    hc_head_store #(.Q(Q), .B(B), .QD(QD), .DW(DW), .QW(QW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (land_valid),
        .wr_qid    (land_qid),
        .wr_cells  (rsp_cells),
        .pop_valid (stg_vld[PIPE-1]),
        .pop_qid   (stg_qid[PIPE-1]),
        .occ       (occ),
        .out_valid (cell_valid),
        .out_qid   (cell_qid),
        .out_data  (cell_data)
    );

    // R1
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_vld[PIPE-1] |=> cell_valid && cell_qid == $past(stg_qid[PIPE-1]));

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_vld[PIPE-1] |=> !cell_valid);

endmodule

// File: tb/hc_head_cache_test.sv
module hc_head_cache_test;

    localparam int NQ      = 4;
    localparam int BLK     = 4;
    localparam int CDW     = 16;
    localparam int LATENCY = NQ * (BLK - 1) + 1 + 1 + 1;   // R1: 15 cycles

    localparam logic [3:0] K_IDLE = 4'd0, K_SAME = 4'd1, K_RR = 4'd2,
                           K_RND  = 4'd3, K_ALT  = 4'd4, K_GAP = 4'd5;

    // {length, pattern, queue}
    localparam logic [15:0] STIM [10] = '{
        {8'd20, K_SAME, 4'd0}, {8'd40, K_RR,   4'd0}, {8'd10, K_IDLE, 4'd0},
        {8'd60, K_RND,  4'd0}, {8'd30, K_SAME, 4'd3}, {8'd25, K_ALT,  4'd1},
        {8'd50, K_RR,   4'd2}, {8'd5,  K_IDLE, 4'd0}, {8'd80, K_RND,  4'd0},
        {8'd40, K_GAP,  4'd2}
    };

    typedef struct packed {
        logic        v;
        logic [1:0]  q;
        logic [13:0] s;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_qid = '0;
    logic             bulk_rd_valid;
    logic [1:0]       bulk_rd_qid;
    logic [BLK*CDW-1:0] bulk_rd_data = '0;
    logic             cell_valid;
    logic [1:0]       cell_qid;
    logic [CDW-1:0]   cell_data;

    int n_chk = 0, n_fail = 0, n_cells = 0, n_reqs = 0, cyc = 0;
    exp_t exp_in = '0, exp_out = '0;
    exp_t dl [LATENCY];
    logic [13:0] reqcnt [NQ];
    logic [13:0] bseq [NQ];
    int reqs_q [NQ];
    int fetched [NQ];
    int cmd_log [16];
    int n_cmd = 0, last_cmd = 0;
    bit have_cmd = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    hc_head_cache uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_qid (req_qid),
        .bulk_rd_valid (bulk_rd_valid), .bulk_rd_qid (bulk_rd_qid),
        .bulk_rd_data (bulk_rd_data), .cell_valid (cell_valid),
        .cell_qid (cell_qid), .cell_data (cell_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Bench model of the fixed delay.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < LATENCY; i++) dl[i] <= '0;
            exp_out <= '0;
        end else begin
            dl[0] <= exp_in;
            for (int i = 1; i < LATENCY; i++) dl[i] <= dl[i-1];
            exp_out <= dl[LATENCY-1];
        end
    end

    // Output checks and bulk memory model (RD_LAT = 1: data during the command cycle).
    always @(negedge clk) begin
        if (rst_n) begin
            if (cell_valid || exp_out.v) begin
                chk(cell_valid == exp_out.v, "R2 cell presence", int'(cell_valid), int'(exp_out.v));
                if (cell_valid && exp_out.v) begin
                    n_cells++;
                    chk(cell_qid == exp_out.q, "R1 queue after fixed delay", int'(cell_qid), int'(exp_out.q));
                    chk(cell_data == {exp_out.q, exp_out.s}, "R3 per-queue order", int'(cell_data),
                        int'({exp_out.q, exp_out.s}));
                end
            end
            if (bulk_rd_valid) begin
                if (have_cmd) begin
                    chk((cyc - last_cmd) >= BLK && ((cyc - last_cmd) % BLK) == 0,
                        "R4 refill spacing", cyc - last_cmd, BLK);
                end
                chk(fetched[bulk_rd_qid] < reqs_q[bulk_rd_qid], "R5 refill needed",
                    fetched[bulk_rd_qid], reqs_q[bulk_rd_qid]);
                if (n_cmd < 16) cmd_log[n_cmd] = int'(bulk_rd_qid);
                n_cmd++;
                have_cmd = 1;
                last_cmd = cyc;
                // R7: block returned for sampling RD_LAT cycles after the command
                for (int k = 0; k < BLK; k++)
                    bulk_rd_data[k*CDW +: CDW] = {bulk_rd_qid, bseq[bulk_rd_qid] + 14'(k)};
                bseq[bulk_rd_qid] = bseq[bulk_rd_qid] + 14'(BLK);
                fetched[bulk_rd_qid] += BLK;
            end
        end
    end

    task automatic slot(input bit v, input logic [1:0] q);
        req_valid = v;
        req_qid   = q;
        if (v) begin
            exp_in = '{v: 1'b1, q: q, s: reqcnt[q]};
            reqcnt[q] = reqcnt[q] + 14'd1;
            reqs_q[q]++;
            n_reqs++;
        end else begin
            exp_in = '0;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        exp_in = '0;
        for (int q = 0; q < NQ; q++) begin
            reqcnt[q] = '0; bseq[q] = '0; reqs_q[q] = 0; fetched[q] = 0;
        end
        n_cmd = 0; have_cmd = 0;
        repeat (3) begin
            @(negedge clk);
            chk(cell_valid == 1'b0, "R8 reset cell_valid", int'(cell_valid), 0);
            chk(bulk_rd_valid == 1'b0, "R8 reset bulk_rd_valid", int'(bulk_rd_valid), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic drain();
        repeat (LATENCY + 6) slot(1'b0, 2'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        report();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R5: no demand, no refill
        repeat (12) slot(1'b0, 2'd0);
        chk(n_cmd == 0, "R5 idle issues no refill", n_cmd, 0);

        // Table walk
        for (int e = 0; e < 10; e++) begin
            int len  = int'(STIM[e][15:8]);
            int kind = int'(STIM[e][7:4]);
            logic [1:0] bq = STIM[e][1:0];
            for (int t = 0; t < len; t++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (kind)
                    1:       slot(1'b1, bq);
                    2:       slot(1'b1, bq + 2'(t));
                    3:       slot(lfsr[0] | lfsr[5], lfsr[3:2]);
                    4:       slot(1'b1, (t % 2 == 0) ? bq : bq ^ 2'd1);
                    5:       slot(t % 2 == 0, bq);
                    default: slot(1'b0, 2'd0);
                endcase
            end
        end
        drain();
        chk(n_cells == n_reqs, "R2 every request answered", n_cells, n_reqs);

        // R6: urgency by age, queue 3 older than queue 1
        do_reset();
        slot(1'b1, 2'd3);
        slot(1'b1, 2'd1);
        drain();
        chk(n_cmd == 2, "R6 two refills", n_cmd, 2);
        chk(cmd_log[0] == 3, "R6 oldest demand first", cmd_log[0], 3);
        chk(cmd_log[1] == 1, "R6 second refill", cmd_log[1], 1);

        // R6: queue 2 older than queue 0, index must not decide
        do_reset();
        slot(1'b1, 2'd2);
        slot(1'b1, 2'd0);
        drain();
        chk(cmd_log[0] == 2, "R6 age over index", cmd_log[0], 2);
        chk(cmd_log[1] == 0, "R6 age over index second", cmd_log[1], 0);

        // R8: reset in mid-traffic drops waiting requests, order restarts
        for (int t = 0; t < 8; t++) slot(1'b1, 2'(t));
        do_reset();
        n_cells = 0; n_reqs = 0;
        for (int t = 0; t < 24; t++) slot(1'b1, 2'd1);
        drain();
        chk(n_cells == 24, "R8 clean restart", n_cells, 24);

        report();
    end

endmodule